// File: doc/BRIEF.md
# Sprite Memory Upload Port

This block is the byte-wide loading front end for sprite storage. A host processor or a DMA engine first writes a slot-select byte. That byte chooses the pattern that later pattern bytes fill, and the sprite whose attribute record later attribute bytes fill. The host then streams bytes to one fixed data strobe for patterns, or one for attributes. The block keeps its own write pointers and advances them after every byte, so a transfer source can increment its address while the destination port stays fixed.

Pattern storage is addressed linearly: 64 patterns of 256 bytes each, 16384 bytes in all. A burst that runs past the end of one pattern continues into the next one. Attribute storage gives each sprite an 8-byte slot. A record is either 4 bytes long, or 5 bytes long when the record's fourth byte carries the extension flag. The block decides the stride from that byte as the byte is written. Both write ports are registered and are meant to drive simple-dual-port block RAMs directly.

Top module: `sprite_upload_port`

## Requirements
- R1: After reset no write strobe is asserted. The first pattern byte goes to pattern address 0, and the first attribute byte goes to attribute address 0.
- R2: A slot-select write with value S points the pattern pointer at S[5:0]*256 and the sprite index at S[6:0]. Bit 7 of S is not used.
- R3: A pattern-port write with byte D asserts pat_we in the next cycle, with pat_wdata = D and pat_addr = the current pointer. The pointer then advances by one.
- R4: The pattern pointer runs from byte 255 of one pattern to byte 0 of the next, and from address 16383 back to 0.
- R5: The attribute address is sprite*8 + byte index, where byte 0 is X, byte 1 is Y, byte 2 is the palette/flip/rotate byte, byte 3 is the pattern byte, and byte 4 is the extension byte. The index never exceeds 4.
- R6: When byte 3 is written with bit 6 clear, the record ends. The next attribute byte goes to byte 0 of the next sprite.
- R7: When byte 3 is written with bit 6 set, one more byte (byte 4) is taken. After it the next sprite's byte 0 follows.
- R8: The sprite index wraps from 127 to 0.
- R9: A slot-select write in the middle of a record restarts the byte index at 0.
- R10: A cycle without a data strobe produces no write strobe. An attribute write never asserts pat_we, and a pattern write never asserts attr_we.
- R11: If a slot-select write and a data write occur in the same cycle, the data byte is stored at the old pointer. The new selection applies from the next write.
- R12: Attribute writes do not move the pattern pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Slot-select write strobe |
| sel_data | input | 8 | Slot-select value |
| pat_wr | input | 1 | Pattern data port write strobe |
| attr_wr | input | 1 | Attribute data port write strobe |
| wr_data | input | 8 | Data byte for either data port |
| pat_we | output | 1 | Pattern RAM write enable |
| pat_addr | output | 14 | Pattern RAM write address |
| pat_wdata | output | 8 | Pattern RAM write data |
| attr_we | output | 1 | Attribute RAM write enable |
| attr_addr | output | 10 | Attribute RAM write address |
| attr_wdata | output | 8 | Attribute RAM write data |

## Verification
Every write result appears exactly one cycle after its strobe, because one output register sits between the strobe and the RAM port. The bench drives each strobe for one cycle starting at a falling edge. It samples the write port just after the next rising edge, then drops the strobe. Pointer movement is never read directly. It is checked through the address of the following write, which is due one cycle after that write's own strobe. Idle-cycle checks sample one cycle after a strobe-free edge.

// File: rtl/sprite_upload_pkg.sv
package sprite_upload_pkg;
  // Position of a byte inside a sprite's attribute record
  localparam int unsigned REC_SLOT_W   = 3;  // 8 address slots per sprite
  localparam int unsigned REC_IDX_PAT  = 3;  // pattern byte, carries the extension flag
  localparam int unsigned REC_IDX_EXT  = 4;  // optional fifth byte
  localparam int unsigned EXT_FLAG_BIT = 6;  // flag bit in the pattern byte

  typedef struct packed {
    logic       we;
    logic [7:0] data;
  } wr_beat_t;
endpackage

// File: rtl/spr_pat_ptr.sv
module spr_pat_ptr #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned OFF_W = 8,
  localparam int unsigned AW   = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             adv,
  output logic [AW-1:0]    ptr
);
  // Linear pointer; carry out of the offset field steps into the next pattern
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= {load_idx, {OFF_W{1'b0}}};
    end else if (adv) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/spr_attr_ptr.sv
module spr_attr_ptr
  import sprite_upload_pkg::*;
#(
  parameter int unsigned SPR_W  = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = SPR_W + REC_SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SPR_W-1:0]  load_spr,
  input  logic              adv,
  input  logic [DATA_W-1:0] byte_in,
  output logic [AW-1:0]     addr
);
  logic [SPR_W-1:0]      spr_q;
  logic [REC_SLOT_W-1:0] idx_q;
  logic                  rec_end;

  // Record ends after byte 4, or after byte 3 when no extension is flagged
  always_comb begin
    rec_end = (idx_q == REC_SLOT_W'(REC_IDX_EXT)) ||
              ((idx_q == REC_SLOT_W'(REC_IDX_PAT)) && !byte_in[EXT_FLAG_BIT]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      spr_q <= load_spr;
      idx_q <= '0;
    end else if (adv) begin
      if (rec_end) begin
        spr_q <= spr_q + 1'b1;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign addr = {spr_q, idx_q};
endmodule

// File: rtl/sprite_upload_port.sv
module sprite_upload_port
  import sprite_upload_pkg::*;
#(
  parameter int unsigned PAT_COUNT = 64,
  parameter int unsigned PAT_BYTES = 256,
  parameter int unsigned SPR_COUNT = 128,
  parameter int unsigned DATA_W    = 8,
  localparam int unsigned PAT_IW   = $clog2(PAT_COUNT),
  localparam int unsigned PAT_OW   = $clog2(PAT_BYTES),
  localparam int unsigned PAT_AW   = PAT_IW + PAT_OW,
  localparam int unsigned SPR_W    = $clog2(SPR_COUNT),
  localparam int unsigned ATTR_AW  = SPR_W + REC_SLOT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_wr,
  input  logic [DATA_W-1:0]  sel_data,
  input  logic               pat_wr,
  input  logic               attr_wr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               pat_we,
  output logic [PAT_AW-1:0]  pat_addr,
  output logic [DATA_W-1:0]  pat_wdata,
  output logic               attr_we,
  output logic [ATTR_AW-1:0] attr_addr,
  output logic [DATA_W-1:0]  attr_wdata
);
  logic [PAT_AW-1:0]  pat_ptr;
  logic [ATTR_AW-1:0] attr_ptr;

  spr_pat_ptr #(
    .IDX_W (PAT_IW),
    .OFF_W (PAT_OW)
  ) i_pat_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (sel_wr),
    .load_idx (sel_data[PAT_IW-1:0]),
    .adv      (pat_wr),
    .ptr      (pat_ptr)
  );

  spr_attr_ptr #(
    .SPR_W  (SPR_W),
    .DATA_W (DATA_W)
  ) i_attr_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (sel_wr),
    .load_spr (sel_data[SPR_W-1:0]),
    .adv      (attr_wr),
    .byte_in  (wr_data),
    .addr     (attr_ptr)
  );

  // Registered RAM write ports: address taken before any pointer update
  always_ff @(posedge clk) begin
    if (rst) begin
      pat_we     <= 1'b0;
      pat_addr   <= '0;
      pat_wdata  <= '0;
      attr_we    <= 1'b0;
      attr_addr  <= '0;
      attr_wdata <= '0;
    end else begin
      pat_we  <= pat_wr;
      attr_we <= attr_wr;
      if (pat_wr) begin
        pat_addr  <= pat_ptr;
        pat_wdata <= wr_data;
      end
      if (attr_wr) begin
        attr_addr  <= attr_ptr;
        attr_wdata <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sprite_upload_chk.sv
module sprite_upload_chk #(
  parameter int unsigned PAT_AW  = 14,
  parameter int unsigned ATTR_AW = 10,
  parameter int unsigned DATA_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               sel_wr,
  input logic               pat_wr,
  input logic               attr_wr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               pat_we,
  input logic [PAT_AW-1:0]  pat_addr,
  input logic [DATA_W-1:0]  pat_wdata,
  input logic               attr_we,
  input logic [ATTR_AW-1:0] attr_addr,
  input logic [DATA_W-1:0]  attr_wdata
);
  // R3
  pat_we_follows_chk: assert property (@(posedge clk) disable iff (rst)
    pat_we == $past(pat_wr));
  // R3
  pat_data_chk: assert property (@(posedge clk) disable iff (rst)
    pat_we |-> pat_wdata == $past(wr_data));
  // R4
  pat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pat_we && $past(pat_we) && !$past(sel_wr, 2)) |->
      pat_addr == PAT_AW'($past(pat_addr) + 1'b1));
  // R10
  attr_we_follows_chk: assert property (@(posedge clk) disable iff (rst)
    attr_we == $past(attr_wr));
  // R5
  attr_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    attr_we |-> attr_addr[2:0] <= 3'd4);
  // R5
  attr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (attr_we && $past(attr_we) && !$past(sel_wr, 2) && $past(attr_addr[2:0]) < 3'd3) |->
      attr_addr == ATTR_AW'($past(attr_addr) + 1'b1));
  // R7
  attr_data_chk: assert property (@(posedge clk) disable iff (rst)
    attr_we |-> attr_wdata == $past(wr_data));
endmodule

bind sprite_upload_port sprite_upload_chk #(
  .PAT_AW  (PAT_AW),
  .ATTR_AW (ATTR_AW),
  .DATA_W  (DATA_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .sel_wr     (sel_wr),
  .pat_wr     (pat_wr),
  .attr_wr    (attr_wr),
  .wr_data    (wr_data),
  .pat_we     (pat_we),
  .pat_addr   (pat_addr),
  .pat_wdata  (pat_wdata),
  .attr_we    (attr_we),
  .attr_addr  (attr_addr),
  .attr_wdata (attr_wdata)
);

// File: tb/test_sprite_upload_port.sv
module test_sprite_upload_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_wr = 1'b0;
  logic [7:0]  sel_data = '0;
  logic        pat_wr = 1'b0;
  logic        attr_wr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        pat_we;
  logic [13:0] pat_addr;
  logic [7:0]  pat_wdata;
  logic        attr_we;
  logic [9:0]  attr_addr;
  logic [7:0]  attr_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sprite_upload_port i_sprite_upload_port (
    .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_data(sel_data),
    .pat_wr(pat_wr), .attr_wr(attr_wr), .wr_data(wr_data),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
    .attr_we(attr_we), .attr_addr(attr_addr), .attr_wdata(attr_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One-cycle strobe; outputs sampled just after the following rising edge
  task automatic cyc(input bit s, input bit p, input bit a, input logic [7:0] sv, input logic [7:0] d);
    @(negedge clk);
    sel_wr = s; pat_wr = p; attr_wr = a; sel_data = sv; wr_data = d;
    @(posedge clk);
    #1;
    sel_wr = 1'b0; pat_wr = 1'b0; attr_wr = 1'b0;
  endtask

  task automatic sel(input logic [7:0] v);
    cyc(1'b1, 1'b0, 1'b0, v, 8'h00);
  endtask

  task automatic pat(input logic [7:0] d, input int exp, input string req);
    cyc(1'b0, 1'b1, 1'b0, 8'h00, d);
    chk(pat_we === 1'b1, req, int'(pat_we), 1);
    chk(pat_addr === 14'(exp), req, int'(pat_addr), exp);
    chk(pat_wdata === d, req, int'(pat_wdata), int'(d));
    chk(attr_we === 1'b0, "R10", int'(attr_we), 0);
  endtask

  task automatic att(input logic [7:0] d, input int exp, input string req);
    cyc(1'b0, 1'b0, 1'b1, 8'h00, d);
    chk(attr_we === 1'b1, req, int'(attr_we), 1);
    chk(attr_addr === 10'(exp), req, int'(attr_addr), exp);
    chk(attr_wdata === d, req, int'(attr_wdata), int'(d));
    chk(pat_we === 1'b0, "R10", int'(pat_we), 0);
  endtask

  task automatic t_reset;
    chk(pat_we === 1'b0, "R1", int'(pat_we), 0);
    chk(attr_we === 1'b0, "R1", int'(attr_we), 0);
    pat(8'h11, 0, "R1");
    att(8'h22, 0, "R1");
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    chk(pat_we === 1'b0 && attr_we === 1'b0, "R10", int'({pat_we, attr_we}), 0);
  endtask

  task automatic t_pattern;
    sel(8'h85);  // bit 7 ignored -> pattern 5
    pat(8'hA0, 16'h0500, "R2");
    pat(8'hA1, 16'h0501, "R3");
    pat(8'hA2, 16'h0502, "R3");
  endtask

  task automatic t_cross;
    sel(8'h07);
    for (int i = 0; i < 255; i++) cyc(1'b0, 1'b1, 1'b0, 8'h00, 8'(i));
    pat(8'hFF, 16'h07FF, "R4");
    pat(8'h01, 16'h0800, "R4");
    sel(8'h3F);
    for (int i = 0; i < 256; i++) cyc(1'b0, 1'b1, 1'b0, 8'h00, 8'(i));
    pat(8'h5A, 0, "R4");
  endtask

  task automatic t_attr4;
    sel(8'h0A);
    att(8'h10, 80, "R5");
    att(8'h11, 81, "R5");
    att(8'h12, 82, "R5");
    att(8'h05, 83, "R5");
    att(8'h20, 88, "R6");
  endtask

  task automatic t_attr5;
    sel(8'h14);
    att(8'h01, 160, "R7");
    att(8'h02, 161, "R7");
    att(8'h03, 162, "R7");
    att(8'h40, 163, "R7");
    att(8'h04, 164, "R7");
    att(8'h05, 168, "R7");
  endtask

  task automatic t_wrap;
    sel(8'h7F);
    att(8'h01, 1016, "R8");
    att(8'h02, 1017, "R8");
    att(8'h03, 1018, "R8");
    att(8'h00, 1019, "R8");
    att(8'h09, 0, "R8");
  endtask

  task automatic t_midsel;
    sel(8'h02);
    att(8'h01, 16, "R9");
    att(8'h02, 17, "R9");
    sel(8'h02);
    att(8'h03, 16, "R9");
  endtask

  task automatic t_simul;
    sel(8'h03);
    pat(8'h31, 16'h0300, "R11");
    cyc(1'b1, 1'b1, 1'b0, 8'h09, 8'h32);
    chk(pat_we === 1'b1 && pat_addr === 14'h0301, "R11", int'(pat_addr), 16'h0301);
    pat(8'h33, 16'h0900, "R11");
  endtask

  task automatic t_indep;
    sel(8'h04);
    att(8'h01, 32, "R12");
    att(8'h02, 33, "R12");
    att(8'h03, 34, "R12");
    att(8'h04, 35, "R12");
    pat(8'h44, 16'h0400, "R12");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_pattern();
    t_cross();
    t_attr4();
    t_attr5();
    t_wrap();
    t_midsel();
    t_simul();
    t_indep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule